// File: doc/BRIEF.md
# Bus Error Position Capture with One-Shot Interrupt

This block sits beside the protocol engine of a serial bus controller. When the engine reports a bus error with a one-cycle strobe, the block records where in the frame the error happened: an error type, the direction (transmit or receive) and the frame segment code. It packs these into an 8-bit capture register and, if the bus error interrupt is enabled, sets a bus error flag in the interrupt register.

The capture is a one-shot latch. After a capture the block stays locked until software reads the capture register once. While it is locked, later errors change neither the capture register nor the interrupt flag. Reading the interrupt register clears the flag. A separate interrupt line is high while the flag is set and the enable is high.

The control is a two-state machine. `ST_ARMED` waits for an error. `ST_LOCKED` holds the captured value. The transition `T_CAPTURE` goes from `ST_ARMED` to `ST_LOCKED` on an error strobe that arrives in a cycle without a capture-register read. The transition `T_RELEASE` goes from `ST_LOCKED` to `ST_ARMED` on a capture-register read. In every other case the machine stays in its current state.

Top module: `bus_err_capture`

## Requirements
- R1: A bus error taken in `ST_ARMED` sets the interrupt flag only when `irq_en` is 1 in that cycle. With `irq_en` at 0 the capture still happens, but the flag stays clear.
- R2: A bus error taken in `ST_ARMED` loads the capture register one cycle later with `{err_type, err_dir, err_seg}`: bits 7:6 hold the type, bit 5 the direction and bits 4:0 the segment code.
- R3: In `ST_LOCKED` the capture register keeps its value. A read of the capture register (`rd_en` = 1 with `rd_addr` = CAP_ADDR, default 12) returns the block to `ST_ARMED`, so the next error is captured.
- R4: A read of the interrupt register (`rd_en` = 1 with `rd_addr` = IRQ_ADDR, default 3) clears the flag on the next edge. If a flag-setting error arrives in the same cycle, the set wins.
- R5: In `ST_LOCKED` no error strobe sets the interrupt flag, even after the flag has been cleared.
- R6: If a capture-register read and an error strobe arrive in the same cycle, the read takes effect and the error is dropped: no capture and no flag.
- R7: `irq_o` is 1 exactly when the flag is set and `irq_en` is 1. Both are sampled in the current cycle.
- R8: After reset the capture register reads 0, the block is in `ST_ARMED` and the flag is clear.
- R9: `rd_data` is combinational on `rd_addr`. It shows the capture register at CAP_ADDR, and the flag in bit 0 with the other bits zero at IRQ_ADDR. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 1 | One-cycle bus error report from the protocol engine |
| err_type | input | 2 | Error type code |
| err_dir | input | 1 | Direction in which the error occurred |
| err_seg | input | 5 | Frame segment code at the time of the error |
| irq_en | input | 1 | Bus error interrupt enable |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | 5 | CPU register address |
| rd_data | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a capture-register read and an error strobe in the same cycle. It matters in both states: in `ST_LOCKED` the read must release the lock without taking the new error, and in `ST_ARMED` the error must still be dropped. Directed sequences first force a lock, then apply both strobes together. They then issue a separate error to show that the dropped one left no trace. A long stretch of random strobes and reads, with the error strobe and the reads weighted to collide often, then compares every cycle against a behavioural model.

// File: rtl/bec_pkg.sv
package bec_pkg;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_LOCKED = 1'b1
    } bec_state_e;

    localparam int TYPE_W = 2;
    localparam int SEG_W  = 5;
    localparam int CAP_W  = TYPE_W + 1 + SEG_W;

    typedef struct packed {
        logic [TYPE_W-1:0] etype;
        logic              dir;
        logic [SEG_W-1:0]  seg;
    } bec_code_t;

endpackage

// File: rtl/bec_capture_fsm.sv
module bec_capture_fsm
    import bec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      err_strobe,
    input  logic      cap_rd,
    input  bec_code_t code_in,
    output logic      take,
    output logic      locked,
    output bec_code_t cap_q
);

    bec_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                // T_CAPTURE; a same-cycle capture read drops the error
                if (err_strobe && !cap_rd) begin
                    take    = 1'b1;
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                // T_RELEASE
                if (cap_rd) state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    assign locked = (state_q == ST_LOCKED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= code_in;
    end

endmodule

// File: rtl/bec_irq_flag.sv
module bec_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic irq_en,
    input  logic irq_rd,
    output logic flag_q,
    output logic irq_o
);

    logic set_flag;

    assign set_flag = take && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_flag) flag_q <= 1'b1;   // a new event beats a clearing read
        else if (irq_rd)   flag_q <= 1'b0;
    end

    assign irq_o = flag_q && irq_en;

endmodule

// File: rtl/bec_read_mux.sv
module bec_read_mux #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int CAP_ADDR = 12,
    parameter int IRQ_ADDR = 3,
    parameter int FLAG_BIT = 0
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] cap_val,
    input  logic              flag_q,
    output logic              cap_rd,
    output logic              irq_rd,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_ADDR);
    localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_ADDR);

    logic [DATA_W-1:0] irq_word;

    always_comb begin
        irq_word           = '0;
        irq_word[FLAG_BIT] = flag_q;
    end

    always_comb begin
        if (rd_addr == CAP_A)      rd_data = cap_val;
        else if (rd_addr == IRQ_A) rd_data = irq_word;
        else                       rd_data = '0;
    end

    assign cap_rd = rd_en && (rd_addr == CAP_A);
    assign irq_rd = rd_en && (rd_addr == IRQ_A);

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import bec_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CAP_ADDR = 12,
    parameter int IRQ_ADDR = 3,
    parameter int FLAG_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe,
    input  logic [TYPE_W-1:0] err_type,
    input  logic              err_dir,
    input  logic [SEG_W-1:0]  err_seg,
    input  logic              irq_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CAP_W-1:0]  rd_data,
    output logic              irq_o
);

    bec_code_t code_in;
    bec_code_t cap_q;
    logic      take;
    logic      locked;
    logic      cap_rd;
    logic      irq_rd;
    logic      flag_q;

    assign code_in = '{etype: err_type, dir: err_dir, seg: err_seg};

    bec_capture_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_strobe (err_strobe),
        .cap_rd     (cap_rd),
        .code_in    (code_in),
        .take       (take),
        .locked     (locked),
        .cap_q      (cap_q)
    );

    bec_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .irq_en (irq_en),
        .irq_rd (irq_rd),
        .flag_q (flag_q),
        .irq_o  (irq_o)
    );

    bec_read_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (CAP_W),
        .CAP_ADDR (CAP_ADDR),
        .IRQ_ADDR (IRQ_ADDR),
        .FLAG_BIT (FLAG_BIT)
    ) u_mux (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cap_val (cap_q),
        .flag_q  (flag_q),
        .cap_rd  (cap_rd),
        .irq_rd  (irq_rd),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/bus_err_capture_chk.sv
module bus_err_capture_chk
    import bec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             err_strobe,
    input logic             irq_en,
    input logic             irq_o,
    input logic [CAP_W-1:0] code_in,
    input logic [CAP_W-1:0] cap_q,
    input logic             locked,
    input logic             cap_rd,
    input logic             irq_rd,
    input logic             flag_q
);

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && err_strobe && !cap_rd) |=> (cap_q == $past(code_in))); // R2

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cap_rd) |=> ($stable(cap_q) && locked)); // R3

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rd && !(!locked && err_strobe && !cap_rd && irq_en)) |=> !flag_q); // R4

    AST_NO_IRQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !$rose(flag_q)); // R5

    AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && cap_rd) |=> (!locked && $stable(cap_q))); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && flag_q)); // R7

endmodule

bind bus_err_capture bus_err_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_strobe (err_strobe),
    .irq_en     (irq_en),
    .irq_o      (irq_o),
    .code_in    (code_in),
    .cap_q      (cap_q),
    .locked     (locked),
    .cap_rd     (cap_rd),
    .irq_rd     (irq_rd),
    .flag_q     (flag_q)
);

// File: tb/bus_err_capture_test.sv
`timescale 1ns/1ps
module bus_err_capture_test;

    localparam int CAP_A = 12;
    localparam int IRQ_A = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_strobe = 1'b0;
    logic [1:0] err_type = '0;
    logic       err_dir = 1'b0;
    logic [4:0] err_seg = '0;
    logic       irq_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_o;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int m_cap = 0;
    bit m_locked = 0;
    bit m_flag = 0;

    always #4 clk = ~clk;

    bus_err_capture uut (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_type(err_type),
        .err_dir(err_dir), .err_seg(err_seg), .irq_en(irq_en), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        if (a == CAP_A) return m_cap;
        if (a == IRQ_A) return m_flag ? 1 : 0;
        return 0;
    endfunction

    // one clock: drive inputs, check combinational outputs, advance model
    task automatic cyc(input string req, input bit e, input int code, input bit en,
                       input bit rd, input int a);
        bit cap_read, irq_read, took;
        @(negedge clk);
        err_strobe = e;
        {err_type, err_dir, err_seg} = 8'(code);
        irq_en = en;
        rd_en = rd;
        rd_addr = 5'(a);
        #1;
        check(req, "rd_data", int'(rd_data), model_rd(a));
        check(req, "irq_o", int'(irq_o), (m_flag && en) ? 1 : 0);
        @(posedge clk);
        cap_read = rd && (a == CAP_A);
        irq_read = rd && (a == IRQ_A);
        took = !m_locked && e && !cap_read;
        if (took) begin
            m_cap = code & 8'hFF;
            m_locked = 1;
            if (en) m_flag = 1;
            else if (irq_read) m_flag = 0;
        end else begin
            if (irq_read) m_flag = 0;
            if (m_locked && cap_read) m_locked = 0;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R8: reset values
        cyc("R8", 0, 0, 1, 0, CAP_A);
        cyc("R8", 0, 0, 1, 0, IRQ_A);
        // R1 R2: capture with enable
        cyc("R2", 1, 8'b10_1_10110, 1, 0, 0);
        cyc("R2", 0, 0, 1, 0, CAP_A);
        cyc("R1", 0, 0, 1, 0, 7);
        // R7: drop enable with flag set
        cyc("R7", 0, 0, 0, 0, 7);
        // R5: error while locked, flag cleared by R4 read, further error
        cyc("R5", 1, 8'h11, 1, 0, 0);
        cyc("R4", 0, 0, 1, 1, IRQ_A);
        cyc("R4", 0, 0, 1, 0, IRQ_A);
        cyc("R5", 1, 8'h22, 1, 0, 0);
        cyc("R5", 0, 0, 1, 0, IRQ_A);
        cyc("R3", 0, 0, 1, 0, CAP_A);
        // R6: release read collides with an error in ST_LOCKED
        cyc("R6", 1, 8'h33, 1, 1, CAP_A);
        cyc("R6", 0, 0, 1, 0, CAP_A);
        // R6: collision again in ST_ARMED
        cyc("R6", 1, 8'h44, 1, 1, CAP_A);
        cyc("R6", 0, 0, 1, 0, CAP_A);
        // R3: armed again, next error captured
        cyc("R3", 1, 8'hE5, 1, 0, 0);
        cyc("R3", 0, 0, 1, 0, CAP_A);
        // R4: set and clear in one cycle, set wins
        cyc("R4", 0, 0, 1, 1, IRQ_A);
        cyc("R4", 0, 0, 1, 1, CAP_A);
        cyc("R4", 1, 8'h5A, 1, 1, IRQ_A);
        cyc("R4", 0, 0, 1, 0, IRQ_A);
        // R1: capture with enable low
        cyc("R1", 0, 0, 0, 1, IRQ_A);
        cyc("R1", 0, 0, 0, 1, CAP_A);
        cyc("R1", 1, 8'h9C, 0, 0, 0);
        cyc("R1", 0, 0, 1, 0, IRQ_A);
        cyc("R1", 0, 0, 1, 0, CAP_A);
        // R9: unused addresses read zero
        for (int a = 0; a < 32; a++) cyc("R9", 0, 0, 1, 0, a);
        // random traffic with frequent collisions
        for (int i = 0; i < 2000; i++) begin
            int sel;
            int a;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? CAP_A : (sel == 1) ? IRQ_A : int'($urandom_range(0, 31));
            cyc("R2", bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
                bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), a);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule